// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This controller takes a processor platform from cold power-up to running and back. It runs on a free-running reference clock, and every time limit is a count of that clock. It waits until the identification supply has been stable before it enables the core regulator. It then bounds how long the core supply may take to come into tolerance. It keeps power-good low for a minimum number of bus clocks, and it holds the processor in reset for a millisecond after power-good rises. Once the processor runs, losing the core supply or the power-good request puts the processor back into reset at once. The sequence then resumes from the power-good wait.

A thermal trip reported by the running processor is latched. The latch removes core power and holds the platform down until a cold restart, which means the identification supply falls away. The trip input is ignored while reset is asserted, because the processor does not drive it reliably then. A regulator that never reports a valid core supply sends the block to a fault state, which keeps reset asserted and raises a sticky flag. A state code output exposes the current phase.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While and after `rst_n` is low, and until the supplies rise, the state code is 0 and `vr_en`, `pwr_good`, `core_kill` and `fault_flag` are 0, with `cpu_rst_n` at 0.
- R2: `vr_en` rises only after `vid_ok` has been sampled high for `CYC_PER_MS` consecutive cycles. Counted from the first clock edge that sees `vid_ok` high, it rises after edge `CYC_PER_MS`+1. A dropout during the wait restarts the count.
- R3: If `core_ok` has not been seen within `CYC_PER_MS*VALID_TMO_MS` cycles after `vr_en` rises, the state becomes FAULT (code 6). In FAULT `vr_en` and `cpu_rst_n` are 0 and `fault_flag` is 1. Only a low `vid_ok` leaves FAULT, and `fault_flag` stays set until `rst_n` is applied.
- R4: `pwr_good` stays low for at least `PG_MIN_BCLK*CYC_PER_BCLK` cycles with `core_ok` high before it rises. It rises only while `pg_req` is high. If the minimum has already elapsed, it rises one edge after `pg_req` goes high.
- R5: `cpu_rst_n` is released exactly `CYC_PER_MS` cycles after `pwr_good` rises.
- R6: When `core_ok` or `pg_req` goes low after release, `cpu_rst_n` falls in the same cycle without waiting for a clock edge. At the next edge `pwr_good` falls and the state returns to the power-good wait (code 3).
- R7: A high `trip_in` while reset is released sets `core_kill` at the next clock edge. The state becomes 7, and `vr_en`, `pwr_good` and `cpu_rst_n` go to 0.
- R8: `trip_in` has no effect while `cpu_rst_n` is 0.
- R9: `core_kill` stays set after `trip_in` falls. It clears, with the state returning to 0, only at the edge after `vid_ok` goes low.
- R10: A low `vid_ok` in any state returns the state to 0 at the next edge.
- R11: State codes: 0 off, 1 identification-supply wait, 2 core ramp, 3 power-good wait, 4 reset hold, 5 run, 6 fault, 7 thermal kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_ok | input | 1 | Identification supply above 1 V |
| core_ok | input | 1 | Core supply within tolerance |
| pg_req | input | 1 | Platform power-good request |
| trip_in | input | 1 | Thermal trip flag from the processor |
| vr_en | output | 1 | Core regulator output enable |
| pwr_good | output | 1 | Internal power-good to the processor |
| cpu_rst_n | output | 1 | Active-low processor reset |
| core_kill | output | 1 | Latched core-supply kill |
| state_code | output | 3 | Current sequencing phase |
| fault_flag | output | 1 | Sticky core-supply timeout fault |

## Verification
On every cycle the assertions check the following:
- every exit from the supply wait, the core ramp, the power-good wait and the reset hold happens only once its counter has reached its limit;
- a low identification supply always forces the off state;
- the fault and kill states never release reset;
- the kill latch holds, and is never set while reset is asserted.

Only the bench scenarios show the exact latencies, measured in edges from an input change to an output change:
- the timeout length;
- the restart after a supply dropout;
- the combinational reset on loss of power-good.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_IDWAIT  = 3'd1,
    ST_RAMP    = 3'd2,
    ST_PGLOW   = 3'd3,
    ST_RSTHOLD = 3'd4,
    ST_RUN     = 3'd5,
    ST_FAULT   = 3'd6,
    ST_TRIP    = 3'd7
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic         sat;
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  assign sat    = &cnt;
  assign cnt_en = clr | ~sat;
  assign cnt_d  = clr ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/pwr_seq_thermal.sv
module pwr_seq_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic released,
  input  logic vid_ok,
  output logic trip_take,
  output logic kill_q
);
  logic kill_d;

  assign trip_take = trip_in & released;

  always_comb begin
    kill_d = kill_q;
    if (!vid_ok)        kill_d = 1'b0;
    else if (trip_take) kill_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= kill_d;
  end

  // R8: the latch is never set while reset is asserted
  p_trip_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!released && !kill_q) |=> !kill_q);

  // R9: kill holds while the identification supply stays up
  p_kill_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && vid_ok) |=> kill_q);

  // R9: a low identification supply clears the latch
  p_kill_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_ok |=> !kill_q);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int W      = 8,
  parameter int MS_CYC = 8,
  parameter int TMO_CYC = 32,
  parameter int PG_CYC = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vid_ok,
  input  logic         core_ok,
  input  logic         pg_req,
  input  logic         trip_take,
  input  logic         kill_q,
  input  logic [W-1:0] cnt,
  output seq_state_e   state_q,
  output logic         cnt_clr,
  output logic         fault_q
);
  localparam logic [W-1:0] MS_LAST  = W'(MS_CYC - 1);
  localparam logic [W-1:0] TMO_LAST = W'(TMO_CYC - 1);
  localparam logic [W-1:0] PG_LAST  = W'(PG_CYC - 1);

  seq_state_e state_d;
  logic       fault_set;

  always_comb begin
    state_d = state_q;
    if (!vid_ok) begin
      state_d = ST_OFF;
    end else if (trip_take || kill_q) begin
      state_d = ST_TRIP;
    end else begin
      case (state_q)
        ST_OFF:     state_d = ST_IDWAIT;
        ST_IDWAIT:  if (cnt == MS_LAST) state_d = ST_RAMP;
        ST_RAMP: begin
          if (core_ok)              state_d = ST_PGLOW;
          else if (cnt == TMO_LAST) state_d = ST_FAULT;
        end
        ST_PGLOW:   if (core_ok && pg_req && cnt >= PG_LAST) state_d = ST_RSTHOLD;
        ST_RSTHOLD: begin
          if (!core_ok || !pg_req)  state_d = ST_PGLOW;
          else if (cnt == MS_LAST)  state_d = ST_RUN;
        end
        ST_RUN:     if (!core_ok || !pg_req) state_d = ST_PGLOW;
        ST_FAULT:   state_d = ST_FAULT;
        ST_TRIP:    state_d = ST_TRIP;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  assign cnt_clr   = (state_d != state_q) | ((state_q == ST_PGLOW) & ~core_ok);
  assign fault_set = (state_q == ST_RAMP) & (state_d == ST_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_set) fault_q <= 1'b1;
  end

  p_vr_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && $past(state_q) != ST_RAMP)
      |-> ($past(state_q) == ST_IDWAIT && $past(cnt) == MS_LAST));

  p_fault_on_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && $past(state_q) == ST_RAMP)
      |-> ($past(cnt) == TMO_LAST && !$past(core_ok)));

  p_fault_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

  p_pg_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RSTHOLD && $past(state_q) == ST_PGLOW)
      |-> ($past(cnt) >= PG_LAST && $past(pg_req)));

  p_reset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_RSTHOLD) |-> $past(cnt) == MS_LAST);

  p_cold_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_ok |=> state_q == ST_OFF);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CYC_PER_MS   = 100000,
  parameter int VALID_TMO_MS = 50,
  parameter int PG_MIN_BCLK  = 10,
  parameter int CYC_PER_BCLK = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vid_ok,
  input  logic       core_ok,
  input  logic       pg_req,
  input  logic       trip_in,
  output logic       vr_en,
  output logic       pwr_good,
  output logic       cpu_rst_n,
  output logic       core_kill,
  output logic [2:0] state_code,
  output logic       fault_flag
);
  localparam int TMO_CYC = CYC_PER_MS * VALID_TMO_MS;
  localparam int PG_CYC  = PG_MIN_BCLK * CYC_PER_BCLK;
  localparam int CNT_MAX = max3(CYC_PER_MS, TMO_CYC, PG_CYC);
  localparam int W       = $clog2(CNT_MAX + 1);

  seq_state_e   state_q;
  logic [W-1:0] cnt;
  logic         cnt_clr;
  logic         released;
  logic         trip_take;
  logic         kill_q;
  logic         fault_q;

  pwr_seq_timer #(.W(W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  pwr_seq_fsm #(
    .W       (W),
    .MS_CYC  (CYC_PER_MS),
    .TMO_CYC (TMO_CYC),
    .PG_CYC  (PG_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .vid_ok    (vid_ok),
    .core_ok   (core_ok),
    .pg_req    (pg_req),
    .trip_take (trip_take),
    .kill_q    (kill_q),
    .cnt       (cnt),
    .state_q   (state_q),
    .cnt_clr   (cnt_clr),
    .fault_q   (fault_q)
  );

  pwr_seq_thermal u_thermal (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_in   (trip_in),
    .released  (released),
    .vid_ok    (vid_ok),
    .trip_take (trip_take),
    .kill_q    (kill_q)
  );

  // Reset drops combinationally on loss of a run condition (R6)
  assign released   = (state_q == ST_RUN) & vid_ok & core_ok & pg_req;
  assign cpu_rst_n  = released;
  assign vr_en      = (state_q == ST_RAMP) | (state_q == ST_PGLOW) |
                      (state_q == ST_RSTHOLD) | (state_q == ST_RUN);
  assign pwr_good   = (state_q == ST_RSTHOLD) | (state_q == ST_RUN);
  assign core_kill  = kill_q;
  assign state_code = state_q;
  assign fault_flag = fault_q;

  p_release_needs_pg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> pwr_good);

  p_fault_keeps_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd6) |-> (!cpu_rst_n && !vr_en));

  p_kill_shuts_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_kill |-> (!vr_en && !cpu_rst_n && !pwr_good));
endmodule

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int MS   = 8;
  localparam int TMOM = 4;
  localparam int PGB  = 10;
  localparam int BCR  = 2;
  localparam int TMO  = MS * TMOM;
  localparam int PGM  = PGB * BCR;

  logic clk = 1'b0;
  logic rst_n, vid_ok, core_ok, pg_req, trip_in;
  logic vr_en, pwr_good, cpu_rst_n, core_kill, fault_flag;
  logic [2:0] state_code;
  int nchk = 0;
  int nerr = 0;
  int n;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(
    .CYC_PER_MS(MS), .VALID_TMO_MS(TMOM), .PG_MIN_BCLK(PGB), .CYC_PER_BCLK(BCR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vid_ok(vid_ok), .core_ok(core_ok), .pg_req(pg_req),
    .trip_in(trip_in), .vr_en(vr_en), .pwr_good(pwr_good), .cpu_rst_n(cpu_rst_n),
    .core_kill(core_kill), .state_code(state_code), .fault_flag(fault_flag)
  );

  typedef struct packed {
    logic vid, core, pgr, trip;
    logic [7:0] wait_n;
    logic [2:0] st;
    logic vr, pg, rn, kill;
  } vec_t;

  // R11 phase walk: inputs, edges to wait, expected state and outputs
  localparam vec_t VEC [0:8] = '{
    '{1'b0,1'b0,1'b0,1'b0, 8'd2,  3'd0, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 8'd4,  3'd1, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0, 8'd6,  3'd2, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0, 8'd2,  3'd3, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0, 8'd20, 3'd4, 1'b1,1'b1,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b0, 8'd9,  3'd5, 1'b1,1'b1,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1, 8'd2,  3'd7, 1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b1,1'b0, 8'd3,  3'd7, 1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b0, 8'd2,  3'd0, 1'b0,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vid_ok = 1'b0; core_ok = 1'b0; pg_req = 1'b0; trip_in = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R1 state in reset", state_code, 0);
    chk("R1 outputs in reset", {vr_en, pwr_good, cpu_rst_n, core_kill, fault_flag}, 0);
    @(negedge clk) rst_n = 1'b1;
    tick();
    chk("R1 state after reset", state_code, 0);
    chk("R1 outputs after reset", {vr_en, pwr_good, cpu_rst_n, core_kill, fault_flag}, 0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      vid_ok = VEC[i].vid; core_ok = VEC[i].core; pg_req = VEC[i].pgr; trip_in = VEC[i].trip;
      repeat (VEC[i].wait_n) @(posedge clk);
      #1;
      chk($sformatf("R11 row%0d state", i), state_code, VEC[i].st);
      chk($sformatf("R11 row%0d outputs", i), {vr_en, pwr_good, cpu_rst_n, core_kill},
          {VEC[i].vr, VEC[i].pg, VEC[i].rn, VEC[i].kill});
    end

    // R2: exact wait from supply rise to enable
    @(negedge clk) begin vid_ok = 1'b1; core_ok = 1'b0; pg_req = 1'b0; end
    n = 0;
    do begin tick(); n++; end while (!vr_en && n < 1000);
    chk("R2 enable latency", n, MS + 1);
    // R10: dropout returns to off
    @(negedge clk) vid_ok = 1'b0;
    tick();
    chk("R10 state after dropout", state_code, 0);
    chk("R10 enable after dropout", vr_en, 0);
    // R2: a dropout during the wait restarts the count
    @(negedge clk) vid_ok = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) vid_ok = 1'b0;
    @(negedge clk) vid_ok = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!vr_en && n < 1000);
    chk("R2 restarted latency", n, MS + 1);

    // R3: core supply timeout
    n = 0;
    do begin tick(); n++; end while (state_code != 3'd6 && n < 1000);
    chk("R3 timeout length", n, TMO);
    chk("R3 fault flag", fault_flag, 1);
    chk("R3 fault outputs", {vr_en, cpu_rst_n}, 0);
    @(negedge clk) begin core_ok = 1'b1; pg_req = 1'b1; end
    repeat (3) tick();
    chk("R3 fault holds", state_code, 6);
    @(negedge clk) vid_ok = 1'b0;
    tick();
    chk("R3 fault exit to off", state_code, 0);
    chk("R3 flag sticky", fault_flag, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R3 flag cleared by reset", fault_flag, 0);

    // R4/R5: power-good minimum and reset hold
    @(negedge clk) begin vid_ok = 1'b1; core_ok = 1'b0; pg_req = 1'b1; end
    n = 0;
    do begin tick(); n++; end while (!vr_en && n < 1000);
    @(negedge clk) core_ok = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!pwr_good && n < 1000);
    chk("R4 power-good low time", n, PGM + 1);
    n = 0;
    do begin tick(); n++; end while (!cpu_rst_n && n < 1000);
    chk("R5 reset hold", n, MS);

    // R6: loss of request
    @(negedge clk) pg_req = 1'b0;
    #1;
    chk("R6 reset falls at once", cpu_rst_n, 0);
    tick();
    chk("R6 state back to wait", state_code, 3);
    chk("R6 power-good dropped", pwr_good, 0);
    repeat (40) tick();
    chk("R4 gated by request", {state_code, pwr_good}, {3'd3, 1'b0});
    @(negedge clk) pg_req = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!pwr_good && n < 1000);
    chk("R4 request after minimum", n, 1);
    n = 0;
    do begin tick(); n++; end while (!cpu_rst_n && n < 1000);
    chk("R5 reset hold again", n, MS);

    // R6: loss of core supply, then recovery re-runs the minimum
    @(negedge clk) core_ok = 1'b0;
    #1;
    chk("R6 reset falls on core loss", cpu_rst_n, 0);
    tick();
    chk("R6 state on core loss", state_code, 3);
    @(negedge clk) core_ok = 1'b1;
    n = 0;
    do begin tick(); n++; end while (!pwr_good && n < 1000);
    chk("R6 power-good low re-run", n, PGM);

    // R8: trip ignored during reset hold
    @(negedge clk) trip_in = 1'b1;
    repeat (3) tick();
    chk("R8 no kill during reset", core_kill, 0);
    @(negedge clk) trip_in = 1'b0;
    n = 0;
    do begin tick(); n++; end while (state_code != 3'd5 && n < 1000);
    chk("R8 run reached without kill", {state_code, core_kill}, {3'd5, 1'b0});

    // R7: trip while running
    @(negedge clk) trip_in = 1'b1;
    tick();
    chk("R7 kill latency", core_kill, 1);
    chk("R7 kill state", state_code, 7);
    chk("R7 outputs on kill", {vr_en, pwr_good, cpu_rst_n}, 0);
    @(negedge clk) trip_in = 1'b0;
    repeat (5) tick();
    chk("R9 kill latched", {core_kill, state_code}, {1'b1, 3'd7});
    @(negedge clk) vid_ok = 1'b0;
    tick();
    chk("R9 cold restart clears kill", {core_kill, state_code}, {1'b0, 3'd0});

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule